// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block turns host data delivered in two 16-bit halves into one 32-bit ARINC 429 word. It sends the word one bit per transmit clock period, then sends a fixed four-period null gap. A buffer register sits in front of an output shift register. While one word is shifting onto the line, the host can already load the next one.

The host writes each half with an active-low strobe and a half-select line. The strobe and the select are synchronized into the transmit clock domain. The data bus is sampled when the synchronized strobe rise is seen, so the bus and the select must stay valid for at least three clock periods after the strobe rises.

The line side has three outputs:
- two digital driver controls that encode one, zero and null for an external line driver;
- a plain serial data output;
- an active-low sync pulse in bit 8, for the older 561-style receivers.

Top module: `a429_tx`

## Requirements
- R1: A write with `host_sel` high fills ARINC bits 1–16, and a write with `host_sel` low fills ARINC bits 17–32. In each half, bus bit 0 goes to the lowest ARINC bit of that half. ARINC bit 1 is sent first, so the word on the line equals {second half, first half} sent LSB first.
- R2: A write is taken on the rise of `host_wr_n`. The rise is seen after two clock edges and acted on at the next edge. When the line is idle, the first bit of a completed word appears after the fourth clock edge that follows the strobe rise.
- R3: `host_rdy` is 1 while the buffer does not hold a complete word. It goes to 0 on the edge that stores the second of the two halves.
- R4: Between two back-to-back words the line sends exactly 4 null bit periods.
- R5: The buffer moves to the shift register in the 4th gap period of the word that is on the line. If no word is on the line, it moves on the first edge after the buffer fills. `host_rdy` returns to 1 on that move, and it stays 0 while a full buffer waits for a gap.
- R6: When `par_en` is 1 at the move, bit 32 is set so that the 32 bits have an odd number of ones. When `par_en` is 0, bit 32 is bus bit 15 of the second half.
- R7: While `rst_n` is low, all state is cleared. After reset, `host_rdy` is 1 and the line stays null until a complete word has been loaded.
- R8: The line encoding is: one = `line_a` 1 and `line_b` 0; zero = `line_a` 0 and `line_b` 1; null = both 0. Both outputs are never 1 at the same time.
- R9: `nrz_data` equals the bit on the line during the 32 data periods and is 0 in the gap. `sync_n` is 0 only during the low phase of the clock in the 8th data period of each word; it is 1 at all other times.
- R10: Writing the same half twice keeps the second value, leaves `host_rdy` at 1 and starts no transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock, one line bit per period |
| rst_n | input | 1 | Active-low reset |
| host_data | input | 16 | Parallel half-word from the host |
| host_sel | input | 1 | 1 selects ARINC bits 1–16, 0 selects bits 17–32 |
| host_wr_n | input | 1 | Active-low write strobe, taken on its rise |
| host_rdy | output | 1 | 1 while the buffer can accept a new word |
| par_en | input | 1 | 1 replaces bit 32 with the odd parity bit |
| line_a | output | 1 | Driver control, high for a one |
| line_b | output | 1 | Driver control, high for a zero |
| nrz_data | output | 1 | Serial data bit, 0 in the gap |
| sync_n | output | 1 | Active-low sync in the low phase of bit 8 |

## Verification
Asymmetric half-words such as 1234/8ABC expose any swap of the halves or reversal of bit order. Parity words test three cases: one where bus bit 15 is 1 but parity must clear it, one with no ones where parity must set it, and one with parity off where bit 15 must pass through. A word written while the line is idle is timed edge by edge from the strobe rise. A second word loaded while the first is still shifting tells apart a move held to the 4th gap slot from one made too early or too late. A repeated write to the same half shows whether a duplicate half is wrongly counted as a complete word.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

   // Driver control pair {a, b}
   typedef enum logic [1:0] {
      LN_NULL = 2'b00,
      LN_ONE  = 2'b10,
      LN_ZERO = 2'b01
   } line_sym_e;

   function automatic line_sym_e sym_of(input logic active, input logic value);
      if (!active)   return LN_NULL;
      else if (value) return LN_ONE;
      else           return LN_ZERO;
   endfunction

endpackage

// File: rtl/a429_host_sync.sv
module a429_host_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_n_in,
   input  logic sel_in,
   output logic wr_rise,
   output logic sel_q
);

   logic [STAGES-1:0] wr_sh;
   logic [STAGES-1:0] sel_sh;
   logic              wr_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("a429_host_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  wr_sh[i]  <= 1'b1;
                  sel_sh[i] <= 1'b0;
               end else begin
                  wr_sh[i]  <= wr_n_in;
                  sel_sh[i] <= sel_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  wr_sh[i]  <= 1'b1;
                  sel_sh[i] <= 1'b0;
               end else begin
                  wr_sh[i]  <= wr_sh[i-1];
                  sel_sh[i] <= sel_sh[i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b1;
      else        wr_prev <= wr_sh[STAGES-1];
   end

   assign wr_rise = wr_sh[STAGES-1] & ~wr_prev;
   assign sel_q   = sel_sh[STAGES-1];

   // R2
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise |=> !wr_rise);

endmodule

// File: rtl/a429_word_buffer.sv
module a429_word_buffer #(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_rise,
   input  logic              sel,
   input  logic [HALF_W-1:0] data,
   input  logic              take,
   output logic [WORD_W-1:0] word,
   output logic              full
);

   logic [HALF_W-1:0] lo_q, hi_q;
   logic              lo_v, hi_v;

   assign full = lo_v & hi_v;
   assign word = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         lo_v <= 1'b0;
         hi_v <= 1'b0;
      end else begin
         if (take) begin
            lo_v <= 1'b0;
            hi_v <= 1'b0;
         end
         if (wr_rise && !full) begin
            if (sel) begin
               lo_q <= data;
               lo_v <= 1'b1;
            end else begin
               hi_q <= data;
               hi_v <= 1'b1;
            end
         end
      end
   end

   // R3
   fill_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && !full && sel && hi_v) |=> full);

   // R10
   same_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && !full && sel && !hi_v) |=> !full);

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer #(
   parameter int WORD_W   = 32,
   parameter int GAP_BITS = 4,
   localparam int SLOTS   = WORD_W + GAP_BITS,
   localparam int CW      = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              full,
   input  logic              par_en,
   output logic              take,
   output logic              in_data,
   output logic              data_bit,
   output logic [CW-1:0]     cnt
);

   logic [WORD_W-1:0] shreg;
   logic              busy;
   logic              top_bit;

   generate
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("a429_serializer: GAP_BITS must be at least 1");
      end
   endgenerate

   assign take     = full & (~busy | (cnt == CW'(SLOTS - 1)));
   assign in_data  = busy & (cnt < CW'(WORD_W));
   assign data_bit = shreg[0];
   assign top_bit  = par_en ? ~(^word[WORD_W-2:0]) : word[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         busy  <= 1'b0;
         cnt   <= '0;
      end else if (take) begin
         shreg <= {top_bit, word[WORD_W-2:0]};
         busy  <= 1'b1;
         cnt   <= '0;
      end else if (busy) begin
         shreg <= shreg >> 1;
         if (cnt == CW'(SLOTS - 1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R6
   parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && par_en) |=> (^shreg));

   // R6
   d15_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !par_en) |=> (shreg[WORD_W-1] == $past(word[WORD_W-1])));

   // R4
   gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && cnt == CW'(WORD_W - 1)) |=> !in_data);

endmodule

// File: rtl/a429_line_encode.sv
module a429_line_encode
   import a429_tx_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int SYNC_BIT = 8,
   parameter int CW       = 6
) (
   input  logic          clk,
   input  logic          in_data,
   input  logic          data_bit,
   input  logic [CW-1:0] cnt,
   output logic          line_a,
   output logic          line_b,
   output logic          nrz_data,
   output logic          sync_n
);

   line_sym_e sym;

   generate
      if (SYNC_BIT < 1 || SYNC_BIT > WORD_W) begin : g_bad_sync
         $error("a429_line_encode: SYNC_BIT out of range");
      end
   endgenerate

   always_comb begin
      sym = sym_of(in_data, data_bit);
   end

   assign {line_a, line_b} = sym;
   assign nrz_data = in_data & data_bit;
   assign sync_n   = ~(in_data & (cnt == CW'(SYNC_BIT - 1)) & ~clk);

   // R8
   never_both_chk: assert property (@(posedge clk) !(line_a && line_b));

endmodule

// File: rtl/a429_tx.sv
module a429_tx #(
   parameter int HALF_W      = 16,
   parameter int GAP_BITS    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SYNC_BIT    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] host_data,
   input  logic              host_sel,
   input  logic              host_wr_n,
   output logic              host_rdy,
   input  logic              par_en,
   output logic              line_a,
   output logic              line_b,
   output logic              nrz_data,
   output logic              sync_n
);

   localparam int WORD_W = 2 * HALF_W;
   localparam int SLOTS  = WORD_W + GAP_BITS;
   localparam int CW     = $clog2(SLOTS);

   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("a429_tx: HALF_W must be at least 2");
      end
   endgenerate

   logic              wr_rise, sel_q, take, full, in_data, data_bit;
   logic [WORD_W-1:0] word;
   logic [CW-1:0]     cnt;

   a429_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .wr_n_in(host_wr_n), .sel_in(host_sel),
      .wr_rise(wr_rise), .sel_q(sel_q)
   );

   a429_word_buffer #(.HALF_W(HALF_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .sel(sel_q),
      .data(host_data), .take(take), .word(word), .full(full)
   );

   a429_serializer #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) u_ser (
      .clk(clk), .rst_n(rst_n), .word(word), .full(full), .par_en(par_en),
      .take(take), .in_data(in_data), .data_bit(data_bit), .cnt(cnt)
   );

   a429_line_encode #(.WORD_W(WORD_W), .SYNC_BIT(SYNC_BIT), .CW(CW)) u_enc (
      .clk(clk), .in_data(in_data), .data_bit(data_bit), .cnt(cnt),
      .line_a(line_a), .line_b(line_b), .nrz_data(nrz_data), .sync_n(sync_n)
   );

   assign host_rdy = ~full;

   // R5
   rdy_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> host_rdy);

   // R7
   null_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_data |-> (!line_a && !line_b));

   // R9
   nrz_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_a && !line_b) |-> !nrz_data);

endmodule

// File: tb/tb_a429_tx.sv
module tb_a429_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_data = '0;
   logic        host_sel = 1'b0;
   logic        host_wr_n = 1'b1;
   logic        par_en = 1'b0;
   logic        host_rdy, line_a, line_b, nrz_data, sync_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   a429_tx dut (
      .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_sel(host_sel),
      .host_wr_n(host_wr_n), .host_rdy(host_rdy), .par_en(par_en),
      .line_a(line_a), .line_b(line_b), .nrz_data(nrz_data), .sync_n(sync_n)
   );

   // ---------------- line monitor ----------------
   logic [31:0] rx_word [0:31];
   int          rx_gap  [0:31];
   int          rx_n = 0;
   int          bitpos = 0;
   int          gap_run = 0;
   int          last_gap = 0;
   logic [31:0] cur = '0;
   int          nrz_err = 0, sync_err = 0, line_err = 0;

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (line_a && line_b) line_err++;
         if (line_a || line_b) begin
            if (bitpos == 0) begin
               last_gap = gap_run;
               gap_run  = 0;
            end
            if (sync_n !== ((bitpos == 7) ? 1'b0 : 1'b1)) sync_err++;
            if (nrz_data !== line_a) nrz_err++;
            cur[bitpos] = line_a;
            bitpos++;
            if (bitpos == 32) begin
               if (rx_n < 32) begin
                  rx_word[rx_n] = cur;
                  rx_gap[rx_n]  = last_gap;
               end
               rx_n++;
               bitpos = 0;
            end
         end else begin
            gap_run++;
            if (sync_n !== 1'b1) sync_err++;
            if (nrz_data !== 1'b0) nrz_err++;
            if (bitpos != 0) line_err++;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [15:0] first,
                                            input logic [15:0] second,
                                            input logic pe);
      logic [31:0] w;
      w = {second, first};
      if (pe) w[31] = ~(^w[30:0]);
      return w;
   endfunction

   task automatic write_half(input logic sel, input logic [15:0] d);
      @(posedge clk); #1;
      host_sel = sel;
      host_data = d;
      host_wr_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 host_wr_n = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   task automatic wait_words(input int n);
      for (int i = 0; i < 400 && rx_n < n; i++) @(posedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (50) @(posedge clk);
      @(negedge clk); #1;
      chk(host_rdy === 1'b1, "R7", "ready after reset", 32'(host_rdy), 32'd1);
      chk(rx_n == 0 && gap_run >= 49, "R7", "null line after reset",
          32'(gap_run), 32'd49);
      chk(sync_n === 1'b1, "R9", "sync idle", 32'(sync_n), 32'd1);
   endtask

   task automatic t_basic;
      int base;
      base = rx_n;
      par_en = 1'b0;
      write_half(1'b1, 16'h1234);
      chk(host_rdy === 1'b1, "R3", "ready after one half", 32'(host_rdy), 32'd1);
      write_half(1'b0, 16'h8ABC);
      wait_words(base + 1);
      chk(rx_n == base + 1, "R1", "word count", 32'(rx_n), 32'(base + 1));
      chk(rx_word[base] === 32'h8ABC1234, "R1", "half placement and order",
          rx_word[base], 32'h8ABC1234);
      chk(rx_word[base][31] === 1'b1, "R6", "bit32 is D15 without parity",
          32'(rx_word[base][31]), 32'd1);
      // reversed load order, select decides placement
      write_half(1'b0, 16'h00C3);
      write_half(1'b1, 16'hB001);
      wait_words(base + 2);
      chk(rx_word[base+1] === 32'h00C3B001, "R1", "second half loaded first",
          rx_word[base+1], 32'h00C3B001);
   endtask

   task automatic t_latency;
      int base, n;
      logic rdy_at4;
      base = rx_n;
      par_en = 1'b0;
      repeat (20) @(posedge clk);
      write_half(1'b1, 16'hF00F);
      @(posedge clk); #1;
      host_sel = 1'b0;
      host_data = 16'h0001;
      host_wr_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 host_wr_n = 1'b1;
      n = 0;
      rdy_at4 = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         n++;
         if (n == 4) rdy_at4 = host_rdy;
         if (line_a || line_b) break;
      end
      chk(rdy_at4 === 1'b0, "R3", "ready low once both halves stored",
          32'(rdy_at4), 32'd0);
      chk(n == 5, "R2", "first bit after idle load (negedges)", 32'(n), 32'd5);
      chk(host_rdy === 1'b1, "R5", "ready back at move", 32'(host_rdy), 32'd1);
      wait_words(base + 1);
      chk(rx_word[base] === 32'h0001F00F, "R1", "latency word", rx_word[base],
          32'h0001F00F);
   endtask

   task automatic t_parity;
      int base;
      logic [31:0] e;
      base = rx_n;
      par_en = 1'b1;
      write_half(1'b1, 16'h0001);
      write_half(1'b0, 16'h8000);
      wait_words(base + 1);
      e = exp_word(16'h0001, 16'h8000, 1'b1);
      chk(rx_word[base] === e, "R6", "parity clears D15", rx_word[base], e);
      write_half(1'b1, 16'h0000);
      write_half(1'b0, 16'h0000);
      wait_words(base + 2);
      e = exp_word(16'h0000, 16'h0000, 1'b1);
      chk(rx_word[base+1] === e, "R6", "parity sets bit32", rx_word[base+1], e);
      chk(^rx_word[base+1] === 1'b1, "R6", "odd count", 32'(^rx_word[base+1]), 32'd1);
      par_en = 1'b0;
   endtask

   task automatic t_overwrite;
      int base;
      base = rx_n;
      par_en = 1'b0;
      write_half(1'b1, 16'hAAAA);
      write_half(1'b1, 16'h5555);
      repeat (10) @(posedge clk);
      @(negedge clk); #1;
      chk(host_rdy === 1'b1, "R10", "ready after repeated half", 32'(host_rdy), 32'd1);
      chk(rx_n == base && bitpos == 0 && !line_a && !line_b, "R10",
          "no transmission from repeated half", 32'(rx_n), 32'(base));
      write_half(1'b0, 16'h0F0F);
      wait_words(base + 1);
      chk(rx_word[base] === 32'h0F0F5555, "R10", "later write kept",
          rx_word[base], 32'h0F0F5555);
   endtask

   task automatic t_back_to_back;
      int base;
      base = rx_n;
      par_en = 1'b0;
      write_half(1'b1, 16'h1111);
      write_half(1'b0, 16'h2222);
      write_half(1'b1, 16'h3333);
      write_half(1'b0, 16'hC444);
      @(negedge clk); #1;
      chk(host_rdy === 1'b0, "R5", "full buffer waits for gap", 32'(host_rdy), 32'd0);
      wait_words(base + 2);
      chk(rx_word[base] === 32'h22221111, "R1", "first queued word",
          rx_word[base], 32'h22221111);
      chk(rx_word[base+1] === 32'hC4443333, "R1", "second queued word",
          rx_word[base+1], 32'hC4443333);
      chk(rx_gap[base+1] == 4, "R4", "gap between words", 32'(rx_gap[base+1]), 32'd4);
      @(negedge clk); #1;
      chk(host_rdy === 1'b1, "R5", "ready after second move", 32'(host_rdy), 32'd1);
      repeat (10) @(posedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_basic();
      t_latency();
      t_parity();
      t_overwrite();
      t_back_to_back();
      chk(nrz_err == 0, "R9", "serial data mismatches", 32'(nrz_err), 32'd0);
      chk(sync_err == 0, "R9", "sync pulse mismatches", 32'(sync_err), 32'd0);
      chk(line_err == 0, "R8", "line encoding faults", 32'(line_err), 32'd0);
      finish_run();
   end

endmodule